// File: doc/BRIEF.md
# Programmable Sync Pulse Generator

This block runs on a 100 MHz clock and produces a single-cycle synchronization pulse that is locked to the phase of a 10 MHz reference. The reference is presented as a phase marker input that is high for one 100 MHz cycle out of every ten. The pulse recurs once every n reference periods, giving a period of n × 100 ns for n from 1 to 255. Setting n = 3, for instance, gives a 300 ns period while every pulse still lines up with a reference edge.

An asynchronous restart level lets an external timing source re-align the divider. It passes through a two-flop synchronizer. While the synchronized level is high, each marker restarts the divider and issues a pulse. Counting resumes from the last restarted pulse once the level falls. Several systems that share the restart level therefore emit their pulses in phase. A new divisor is taken only when a pulse is issued, so the period that is running finishes unchanged.

Top module: `sync_pulse_gen`

## Requirements
- R1: `sync_pulse` is never high for two consecutive clock cycles.
- R2: `sync_pulse` is high only in the cycle that directly follows a cycle in which `ref_mark` was high.
- R3: With a constant divisor n (1 to 255), pulses follow every n-th marker. With n = 1 that is every marker, with n = 3 every third marker, and with n = 255 every 255th marker.
- R4: A divisor value of 0 behaves exactly as 1.
- R5: During reset `sync_pulse` is low. The first marker after reset is released produces a pulse.
- R6: A new divisor written between pulses does not shorten or stretch the period already in progress. It sets the spacing that starts at the next pulse.
- R7: A marker that is sampled while the synchronized restart level is high always produces a pulse. The divider count restarts from that pulse.
- R8: The restart input reaches the divider through two flops. A restart level first raised in the cycle just before a marker cycle is not applied to that marker.
- R9: While the restart level is held high, every marker produces a pulse, whatever the divisor is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_mark | input | 1 | 10 MHz phase marker, high one cycle in ten |
| div_n | input | DIV_W (8) | Divisor n; 0 is treated as 1 |
| restart_req | input | 1 | Asynchronous restart level |
| sync_pulse | output | 1 | One-cycle synchronization pulse |

## Verification
Four properties are checked on every cycle: the pulse is one cycle wide, a pulse always follows a marker, a marker seen during a synchronized restart always fires, and the remaining count stays below the latched divisor. Other behaviour depends on the order of events and can only be shown by the bench scenarios. These include the exact spacing for several divisors, the zero-as-one rule, and when a changed divisor takes effect. They also include the two-cycle latency of restart, which the bench shows with a short restart that must be missed, and the pulse on every marker while restart is held.

// File: rtl/sync_pulse_pkg.sv
package sync_pulse_pkg;

   // Result of one divider evaluation
   typedef struct packed {
      logic fire;        // this marker ends a period
      logic by_restart;  // the period was cut by restart
   } tick_t;

   localparam int unsigned MAX_DIV_W = 16;

endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/sps_divider.sv
module sps_divider
   import sync_pulse_pkg::*;
#(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mark,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_in,
   output tick_t            tick
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] rem;
   logic [DIV_W-1:0] n_cur;
   logic [DIV_W-1:0] n_eff;
   logic             at_end;

   always_comb begin
      n_eff           = (div_in == '0) ? ONE : div_in;
      at_end          = (rem == '0);
      tick.fire       = mark && (at_end || restart);
      tick.by_restart = mark && restart && !at_end;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem   <= '0;
         n_cur <= ONE;
      end else if (tick.fire) begin
         rem   <= n_eff - ONE;
         n_cur <= n_eff;
      end else if (mark) begin
         rem   <= rem - ONE;
      end
   end

   // R3: the remaining count never reaches the latched divisor
   a_r3_rem_below_n: assert property (@(posedge clk) disable iff (!rst_n)
      rem < n_cur);

   // R6: the count only moves on a marker
   a_r6_count_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
      !mark |=> $stable(rem) && $stable(n_cur));
endmodule

// File: rtl/sps_emit.sv
module sps_emit #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   generate
      if (OUT_REG) begin : g_reg
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= fire;
         end
         assign pulse = q;
      end else begin : g_comb
         assign pulse = fire && rst_n;
      end
   endgenerate
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
   import sync_pulse_pkg::*;
#(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_mark,
   input  logic [DIV_W-1:0] div_n,
   input  logic             restart_req,
   output logic             sync_pulse
);
   generate
      if (DIV_W < 1 || DIV_W > MAX_DIV_W) begin : g_bad_width
         $error("sync_pulse_gen: DIV_W out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sync_pulse_gen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic  restart_s;
   tick_t tick;

   sps_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (restart_req),
      .dout (restart_s)
   );

   sps_divider #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .mark   (ref_mark),
      .restart(restart_s),
      .div_in (div_n),
      .tick   (tick)
   );

   sps_emit #(.OUT_REG(OUT_REG)) u_emit (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (tick.fire),
      .pulse(sync_pulse)
   );

   generate
      if (OUT_REG) begin : g_chk
         // R1: single-cycle pulse
         a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            sync_pulse |=> !sync_pulse);
         // R2: a pulse always follows a marker cycle
         a_r2_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sync_pulse) |-> $past(ref_mark));
         // R7: a marker during synchronized restart fires
         a_r7_restart_fires: assert property (@(posedge clk) disable iff (!rst_n)
            (restart_s && ref_mark) |=> sync_pulse);
      end
   endgenerate
endmodule

// File: tb/sim_sync_pulse_gen.sv
`timescale 1ns/1ps
module sim_sync_pulse_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_mark = 1'b0;
   logic [7:0] div_n = 8'd1;
   logic       restart_req = 1'b0;
   logic       sync_pulse;

   always #2 clk = ~clk;

   sync_pulse_gen u0 (
      .clk(clk), .rst_n(rst_n), .ref_mark(ref_mark), .div_n(div_n),
      .restart_req(restart_req), .sync_pulse(sync_pulse)
   );

   typedef struct {
      int    at;
      bit    fire;
      string req;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad = 0;
   int   cyc = 0;
   bit   done = 1'b0;

   // reference model state
   int ph = 0;
   int rem = 0;
   bit rq1 = 0, rq2 = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic step(int d, bit r, string tag);
      bit m, eff, f;
      @(negedge clk);
      m  = (ph == 0);
      ph = (ph + 1) % 10;
      ref_mark = m;
      restart_req = r;
      div_n = 8'(d);
      eff = rq2;
      rq2 = rq1;
      rq1 = r;
      f = 1'b0;
      if (m) begin
         if (rem == 0 || eff) begin
            f = 1'b1;
            rem = ((d == 0) ? 1 : d) - 1;
         end else begin
            rem = rem - 1;
         end
         q.push_back('{cyc + 1, f, tag});
      end
   endtask

   task automatic run(int n, int d, bit r, string tag);
      for (int i = 0; i < n; i++) step(d, r, tag);
   endtask

   // monitor: compare output with the queued expectation
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (q.size() > 0 && q[0].at == cyc) begin
            total++;
            if (sync_pulse !== q[0].fire) begin
               bad++;
               $display("FAIL %s: cycle %0d sync_pulse=%0b expected=%0b",
                        q[0].req, cyc, sync_pulse, q[0].fire);
            end
            void'(q.pop_front());
         end else if (sync_pulse !== 1'b0) begin
            total++;
            bad++;
            $display("FAIL R2: cycle %0d sync_pulse=%0b expected=0 (no marker before)",
                     cyc, sync_pulse);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R5: output low during reset
      repeat (5) begin
         @(negedge clk);
         total++;
         if (sync_pulse !== 1'b0) begin
            bad++;
            $display("FAIL R5: in reset sync_pulse=%0b expected=0", sync_pulse);
         end
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R5 and R3: first marker fires, then n = 1 fires on each marker
      run(60, 1, 1'b0, "R3/R5 n=1");
      // R3: n = 3
      run(150, 3, 1'b0, "R3 n=3");
      // R4: n = 0 acts as 1
      run(60, 0, 1'b0, "R4 n=0");
      // R6: change 3 -> 5 between pulses
      run(35, 3, 1'b0, "R6 before change");
      run(200, 5, 1'b0, "R6 after change");
      // R3: n = 255
      run(2600, 255, 1'b0, "R3 n=255");
      // R7: restart with n = 4, one marker catches it
      run(45, 4, 1'b0, "R7 lead-in");
      while (ph != 8) step(4, 1'b0, "R7 align");
      run(3, 4, 1'b1, "R7 restart");
      run(120, 4, 1'b0, "R7 after restart");
      // R8: restart raised the cycle before a marker, dropped before the next
      while (ph != 9) step(6, 1'b0, "R8 align");
      run(2, 6, 1'b1, "R8 short restart");
      run(130, 6, 1'b0, "R8 after short restart");
      // R9: restart held high, every marker fires
      run(80, 7, 1'b1, "R9 held restart");
      run(100, 7, 1'b0, "R9 release");
      ref_mark = 1'b0;
      repeat (3) @(negedge clk);
      total++;
      if (q.size() != 0) begin
         bad++;
         $display("FAIL R3: pending expectations=%0d expected=0", q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule